// File: doc/BRIEF.md
# Dual-Chamber Pacing Controller

This block sequences pacing for two heart chambers, upper (atrial) and lower (ventricular), and watches them in turn. At the start of each chamber's turn it restarts that chamber's countdown timer and then waits. If a natural sense pulse for that chamber arrives while it waits, no pace is needed and control passes to the other chamber. If the timer runs down to zero first, the block emits a one-cycle pace pulse for that chamber and then hands over. The atrial turn is always followed by the ventricular turn, and the ventricular turn by the atrial one.

Both countdown timers are internal. Each reloads a preset interval, given in clock cycles, when the controller restarts it. It then counts down by one each cycle and stops at zero, where it raises a zero flag for the controller. Sense inputs are single-cycle synchronous pulses. Both pace outputs come straight from flip-flops, so they carry no decode glitches. Reset is synchronous and active high.

Top module: `dual_chamber_pacer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, both pace outputs are 0. The first cycle after reset is the atrial restart cycle. Asserting `rst` at any point abandons the sequence in progress and restarts it this way.
- R2: If no atrial sense arrives, `pace_atr` is high for exactly one cycle. That cycle comes PRE_A+2 cycles after the atrial restart cycle, with the restart cycle counted as cycle 0.
- R3: An atrial sense during the atrial wait suppresses that atrial pace. The next cycle is the ventricular restart cycle.
- R4: If no ventricular sense arrives, `pace_ven` is high for exactly one cycle. That cycle comes PRE_V+2 cycles after the ventricular restart cycle. The ventricular restart cycle immediately follows the atrial pace cycle or the atrial sense cycle.
- R5: The cycle after a ventricular pace, or after a ventricular sense during the ventricular wait, is the atrial restart cycle.
- R6: A sense that falls in the same cycle as its chamber's timer reaching zero takes priority, and no pace is issued for that turn.
- R7: A sense pulse has no effect outside its own chamber's wait. This covers the other chamber's wait and the restart and pace cycles.
- R8: The two pace outputs are never high in the same cycle.
- R9: Each restart reloads the full preset, whatever count a timer was left at. Once the count reaches zero it stays there until the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_atr | input | 1 | Natural atrial event, one-cycle pulse |
| sense_ven | input | 1 | Natural ventricular event, one-cycle pulse |
| pace_atr | output | 1 | Atrial pace pulse, registered |
| pace_ven | output | 1 | Ventricular pace pulse, registered |

## Verification
Two things can happen in the same cycle: a chamber's sense pulse can arrive in the very cycle its timer reaches zero. The bench follows the wait length in its own model and injects the sense exactly on the final wait cycle of each chamber. That cycle is the one in which the timer would otherwise trigger a pace. The result is judged at the pace outputs: the expected pulse must be missing, and the other chamber's pace must land on the timing of a fresh turn, which shows the hand-over came from the sense.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    localparam int CH_ATR = 0;
    localparam int CH_VEN = 1;
    localparam int NUM_CH = 2;

    typedef enum logic [2:0] {
        ST_RESTART_A = 3'd0,
        ST_WAIT_A    = 3'd1,
        ST_PACE_A    = 3'd2,
        ST_RESTART_V = 3'd3,
        ST_WAIT_V    = 3'd4,
        ST_PACE_V    = 3'd5
    } pace_state_e;

    typedef struct packed {
        pace_state_e        state;
        logic [NUM_CH-1:0]  reload;
        logic               pace_a;
        logic               pace_v;
    } ctrl_regs_t;

endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
    parameter int PRESET = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic reload_i,
    output logic zero_o
);
    localparam int CW = (PRESET < 1) ? 1 : $clog2(PRESET + 1);
    localparam logic [CW-1:0] PRESET_V = CW'(PRESET);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (rst) begin
            cnt_d = '0;
        end else if (reload_i) begin
            cnt_d = PRESET_V;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R9
    reload_full_chk: assert property (@(posedge clk) disable iff (rst)
        reload_i |=> (cnt_q == PRESET_V));

    // R9
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_o && !reload_i) |=> zero_o);

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_o && !reload_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pace_fsm.sv
module pace_fsm
    import pacer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sense_a,
    input  logic              sense_v,
    input  logic [NUM_CH-1:0] zero_i,
    output logic [NUM_CH-1:0] reload_o,
    output logic              pace_a_o,
    output logic              pace_v_o
);
    ctrl_regs_t r_d, r_q;
    pace_state_e nxt;

    always_comb begin
        nxt = r_q.state;
        unique case (r_q.state)
            ST_RESTART_A: nxt = ST_WAIT_A;
            ST_WAIT_A: begin
                if (sense_a)              nxt = ST_RESTART_V;
                else if (zero_i[CH_ATR])  nxt = ST_PACE_A;
            end
            ST_PACE_A:    nxt = ST_RESTART_V;
            ST_RESTART_V: nxt = ST_WAIT_V;
            ST_WAIT_V: begin
                if (sense_v)              nxt = ST_RESTART_A;
                else if (zero_i[CH_VEN])  nxt = ST_PACE_V;
            end
            ST_PACE_V:    nxt = ST_RESTART_A;
            default:      nxt = ST_RESTART_A;
        endcase
        if (rst) nxt = ST_RESTART_A;

        r_d.state          = nxt;
        r_d.reload[CH_ATR] = (nxt == ST_RESTART_A);
        r_d.reload[CH_VEN] = (nxt == ST_RESTART_V);
        r_d.pace_a         = (nxt == ST_PACE_A);
        r_d.pace_v         = (nxt == ST_PACE_V);
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign reload_o = r_q.reload;
    assign pace_a_o = r_q.pace_a;
    assign pace_v_o = r_q.pace_v;

    // R1
    reset_entry_chk: assert property (@(posedge clk)
        rst |=> (r_q.state == ST_RESTART_A && !pace_a_o && !pace_v_o));

    // R8
    pace_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pace_a_o && pace_v_o));

    // R3
    sense_a_hand_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_WAIT_A && sense_a) |=> (r_q.state == ST_RESTART_V && !pace_a_o));

    // R6
    tie_v_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_WAIT_V && sense_v && zero_i[CH_VEN]) |=> !pace_v_o);

    // R2
    pace_a_width_chk: assert property (@(posedge clk) disable iff (rst)
        pace_a_o |=> (!pace_a_o && reload_o[CH_VEN]));

    // R5
    after_v_chk: assert property (@(posedge clk) disable iff (rst)
        pace_v_o |=> (r_q.state == ST_RESTART_A));

endmodule

// File: rtl/dual_chamber_pacer.sv
module dual_chamber_pacer
    import pacer_pkg::*;
#(
    parameter int PRE_A = 6,
    parameter int PRE_V = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sense_atr,
    input  logic sense_ven,
    output logic pace_atr,
    output logic pace_ven
);
    logic [NUM_CH-1:0] tmr_reload;
    logic [NUM_CH-1:0] tmr_zero;

    pace_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sense_a  (sense_atr),
        .sense_v  (sense_ven),
        .zero_i   (tmr_zero),
        .reload_o (tmr_reload),
        .pace_a_o (pace_atr),
        .pace_v_o (pace_ven)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_tmr
        pace_timer #(
            .PRESET ((g == CH_ATR) ? PRE_A : PRE_V)
        ) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .reload_i (tmr_reload[g]),
            .zero_o   (tmr_zero[g])
        );
    end

endmodule

// File: tb/sim_dual_chamber_pacer.sv
module sim_dual_chamber_pacer;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_A = 6;
    localparam int PRE_V = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sa  = 1'b0;
    logic sv  = 1'b0;
    logic pa, pv;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_chamber_pacer #(.PRE_A(PRE_A), .PRE_V(PRE_V)) u0 (
        .clk(clk), .rst(rst), .sense_atr(sa), .sense_ven(sv),
        .pace_atr(pa), .pace_ven(pv)
    );

    int checks = 0;
    int fails  = 0;
    // model phases: 0 restart A, 1 wait A, 2 pace A, 3 restart V, 4 wait V, 5 pace V
    int m_ph = 0;
    int m_w  = 0;
    bit model_ok = 1'b0;
    string cur_tag = "R1";
    bit [1:0] exp_q[$];
    string tag_q[$];

    task automatic step(input logic r, input logic a, input logic v);
        @(negedge clk);
        if (model_ok) begin
            exp_q.push_back({m_ph == 5, m_ph == 2});
            if (m_ph == 2)      tag_q.push_back("R2");
            else if (m_ph == 5) tag_q.push_back("R4");
            else                tag_q.push_back(cur_tag);
        end
        rst = r; sa = a; sv = v;
        if (r) begin
            m_ph = 0; m_w = 0;
        end else begin
            case (m_ph)
                0: begin m_ph = 1; m_w = 0; end
                1: if (a) m_ph = 3; else if (m_w == PRE_A) m_ph = 2; else m_w++;
                2: m_ph = 3;
                3: begin m_ph = 4; m_w = 0; end
                4: if (v) m_ph = 0; else if (m_w == PRE_V) m_ph = 5; else m_w++;
                default: m_ph = 0;
            endcase
        end
        model_ok = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle_until(input int ph, input int w);
        while (!(m_ph == ph && m_w == w)) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle_to_phase(input int ph);
        while (m_ph != ph) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // monitor: pops each expected item and compares at mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                bit [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({pv, pa} !== e) begin
                    fails++;
                    $display("FAIL %s: pace {ven,atr} actual=%b expected=%b at %0t", t, {pv, pa}, e, $time);
                end
                checks++;
                if (pa === 1'b1 && pv === 1'b1) begin
                    fails++;
                    $display("FAIL R8: both paces high actual=11 expected=not 11 at %0t", $time);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state and start-up
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        // R2, R4, R5, R9: two undisturbed rounds
        cur_tag = "R9";
        idle(2 * (PRE_A + PRE_V + 6));
        // R3: atrial sense part-way through the atrial wait
        cur_tag = "R3";
        idle_until(1, 2);
        step(1'b0, 1'b1, 1'b0);
        idle(20);
        // R5: ventricular sense part-way through the ventricular wait
        cur_tag = "R5";
        idle_until(4, 1);
        step(1'b0, 1'b0, 1'b1);
        idle(12);
        // R6: senses coinciding with timer expiry in each chamber
        cur_tag = "R6";
        idle_until(1, PRE_A);
        step(1'b0, 1'b1, 1'b0);
        idle_until(4, PRE_V);
        step(1'b0, 1'b0, 1'b1);
        idle(PRE_A + 4);
        // R7: senses outside their own wait are ignored
        cur_tag = "R7";
        idle_until(1, 0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1);
        idle_until(4, 0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);
        idle_to_phase(2);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        idle_to_phase(0);
        step(1'b0, 1'b1, 1'b1);
        idle(PRE_A + PRE_V + 8);
        // R1: reset in the middle of a ventricular wait
        cur_tag = "R1";
        idle_until(4, 2);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        cur_tag = "R9";
        idle(PRE_A + PRE_V + 10);
        @(negedge clk);
        #5;
        finish_run();
    end

endmodule